// File: doc/BRIEF.md
# Signed Backward Spike Encoder

This block belongs to the backward pass of a spiking network trainer that uses time-to-first-spike coding. For each output neuron it compares the time at which the neuron actually fired with the time it should have fired. It then expresses that temporal error as one backward spike instead of a stored gradient value. The error magnitude sets when the spike appears: a larger error fires earlier on a 16-step backward time axis. The sign of the error sets the spike's polarity. The datapath uses subtraction, comparison and a right shift, and no multiplier.

A controller presents the 4-bit actual and target times of all neurons, with one valid flag per time, and pulses `start`. The block latches the errors and runs its backward time counter from 0 to 15, asserting `bwd_busy` while the counter runs. At each step it raises the spike lines of the neurons scheduled for that step. After the last step it pulses `bwd_done` for one cycle and returns to idle. Downstream weight-update logic consumes the spikes as they occur.

Top module: `spike_err_encoder`

## Requirements
- R1: The error of a neuron is its effective actual time minus its target time. When a spike is issued, `bwd_pol` for that neuron is 1 if the actual time is later than the target and 0 if it is earlier.
- R2: With the default `ERR_SHIFT` of 0, a neuron's backward spike appears at the step where `bwd_time` equals 15 minus the absolute error, so an error of magnitude 15 fires at step 0.
- R3: A neuron whose error is zero issues no backward spike during the run.
- R4: A neuron whose actual-valid flag is 0 is treated as having fired at time 15 when its error is computed.
- R5: A neuron whose target-valid flag is 0 issues no backward spike, whatever its actual time.
- R6: Each neuron issues at most one single-cycle backward spike per run, and its `bwd_pol` bit is 0 in every cycle in which its spike is low.
- R7: `start` is accepted only while idle and not in the done cycle. In the cycle after it is accepted, `bwd_busy` is 1 and `bwd_time` is 0. `bwd_time` then rises by one per cycle up to 15, with `bwd_busy` held high throughout.
- R8: In the cycle after the step where `bwd_time` is 15, `bwd_done` is 1 for exactly one cycle, `bwd_busy` is 0 and no spike is asserted. The next cycle is idle with `bwd_done` low.
- R9: A `start` pulse while busy is ignored. Time inputs and valid flags are sampled only when `start` is accepted, so changes during a run do not alter its spikes.
- R10: After reset, `bwd_busy`, `bwd_done`, every spike bit and every polarity bit are 0, and `bwd_time` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one backward run (accepted when idle) |
| act_time | input | N_NEUR*4 | Actual spike time of each neuron, neuron i in bits [4i+3:4i] |
| act_vld | input | N_NEUR | Neuron fired in the forward pass |
| tgt_time | input | N_NEUR*4 | Target spike time of each neuron, same packing |
| tgt_vld | input | N_NEUR | Neuron has a target |
| bwd_spike | output | N_NEUR | Backward spike pulse per neuron |
| bwd_pol | output | N_NEUR | Polarity of the spike: 1 = actual later than target |
| bwd_time | output | 4 | Current backward time step |
| bwd_busy | output | 1 | Backward time counter is running |
| bwd_done | output | 1 | One-cycle pulse after the last step |

## Verification
The assertions take for granted that reset is asserted before the first run. They also rely on `start` being the only event that reloads the latched errors, so the once-per-run spike check restarts its bookkeeping on an accepted `start` alone. They make no assumption about the timing of `start`. The bench therefore pulses it mid-run, with different data, and also changes the time and valid inputs while a run is in progress. Each directed run computes its expected spike schedule from the requirements at the moment `start` is accepted, then compares every one of the 16 steps and the done cycle against it.

// File: rtl/snn_bwd_pkg.sv
package snn_bwd_pkg;

    localparam int TIME_W = 4;
    localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // One neuron's scheduled backward event
    typedef struct packed {
        logic              armed;    // a spike will be issued
        logic              late;     // actual later than target
        logic [TIME_W-1:0] fire_at;  // backward step of the spike
    } bwd_slot_t;

    // Absolute difference of two times; late flag tells the sign
    function automatic logic [TIME_W:0] time_delta(input logic [TIME_W-1:0] a,
                                                   input logic [TIME_W-1:0] b);
        logic              later;
        logic [TIME_W-1:0] mag;
        later = (a > b);
        mag   = later ? (a - b) : (b - a);
        return {later, mag};
    endfunction

endpackage

// File: rtl/bwd_err_unit.sv
module bwd_err_unit
    import snn_bwd_pkg::*;
#(
    parameter int ERR_SHIFT = 0
) (
    input  logic [TIME_W-1:0] act_t,
    input  logic              act_ok,
    input  logic [TIME_W-1:0] tgt_t,
    input  logic              tgt_ok,
    output bwd_slot_t         slot
);
    logic [TIME_W-1:0] eff_t;
    logic [TIME_W:0]   delta;
    logic [TIME_W-1:0] mag_sh;

    always_comb begin
        // a silent neuron counts as firing at the last step
        eff_t        = act_ok ? act_t : TIME_MAX;
        delta        = time_delta(eff_t, tgt_t);
        mag_sh       = delta[TIME_W-1:0] >> ERR_SHIFT;
        slot.late    = delta[TIME_W];
        slot.fire_at = TIME_MAX - mag_sh;
        slot.armed   = tgt_ok && (mag_sh != '0);
    end
endmodule

// File: rtl/bwd_slot.sv
module bwd_slot
    import snn_bwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  bwd_slot_t         slot_in,
    input  logic              running,
    input  logic [TIME_W-1:0] t_now,
    output logic              spike,
    output logic              pol
);
    bwd_slot_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= slot_in;
        end
    end

    always_comb begin
        spike = running && held.armed && (held.fire_at == t_now);
        pol   = spike && held.late;
    end
endmodule

// File: rtl/bwd_sequencer.sv
module bwd_sequencer
    import snn_bwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load,
    output logic              running,
    output logic              finished,
    output logic [TIME_W-1:0] t_now
);
    seq_state_e state;

    assign load     = (state == SEQ_IDLE) && start;
    assign running  = (state == SEQ_RUN);
    assign finished = (state == SEQ_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            t_now <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    t_now <= '0;
                    if (start) state <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (t_now == TIME_MAX) state <= SEQ_FIN;
                    else                   t_now <= t_now + TIME_W'(1);
                end
                SEQ_FIN: begin
                    state <= SEQ_IDLE;
                    t_now <= '0;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spike_err_encoder.sv
module spike_err_encoder
    import snn_bwd_pkg::*;
#(
    parameter int N_NEUR    = 10,
    parameter int ERR_SHIFT = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [N_NEUR*TIME_W-1:0] act_time,
    input  logic [N_NEUR-1:0]        act_vld,
    input  logic [N_NEUR*TIME_W-1:0] tgt_time,
    input  logic [N_NEUR-1:0]        tgt_vld,
    output logic [N_NEUR-1:0]        bwd_spike,
    output logic [N_NEUR-1:0]        bwd_pol,
    output logic [TIME_W-1:0]        bwd_time,
    output logic                     bwd_busy,
    output logic                     bwd_done
);
    logic load, running, finished;
    logic [TIME_W-1:0] t_now;

    bwd_sequencer seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (load),
        .running  (running),
        .finished (finished),
        .t_now    (t_now)
    );

    for (genvar i = 0; i < N_NEUR; i++) begin : g_neur
        bwd_slot_t slot_c;

        bwd_err_unit #(.ERR_SHIFT(ERR_SHIFT)) err_i (
            .act_t  (act_time[i*TIME_W +: TIME_W]),
            .act_ok (act_vld[i]),
            .tgt_t  (tgt_time[i*TIME_W +: TIME_W]),
            .tgt_ok (tgt_vld[i]),
            .slot   (slot_c)
        );

        bwd_slot slot_i (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .slot_in (slot_c),
            .running (running),
            .t_now   (t_now),
            .spike   (bwd_spike[i]),
            .pol     (bwd_pol[i])
        );
    end

    assign bwd_time = t_now;
    assign bwd_busy = running;
    assign bwd_done = finished;
endmodule

// File: rtl/spike_err_encoder_chk.sv
module spike_err_encoder_chk
    import snn_bwd_pkg::*;
#(
    parameter int N_NEUR = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [N_NEUR-1:0] bwd_spike,
    input logic [N_NEUR-1:0] bwd_pol,
    input logic [TIME_W-1:0] bwd_time,
    input logic              bwd_busy,
    input logic              bwd_done
);
    logic [N_NEUR-1:0] seen;
    logic accepted;

    assign accepted = start && !bwd_busy && !bwd_done;

    always_ff @(posedge clk) begin
        if (rst || accepted) seen <= '0;
        else                 seen <= seen | bwd_spike;
    end

    p_single_spike_r6: assert property (@(posedge clk) disable iff (rst)
        (bwd_spike & seen) == '0);

    p_pol_needs_spike_r6: assert property (@(posedge clk) disable iff (rst)
        (bwd_pol & ~bwd_spike) == '0);

    p_spike_in_run_r8: assert property (@(posedge clk) disable iff (rst)
        (bwd_spike != '0) |-> bwd_busy);

    p_start_run_r7: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (bwd_busy && bwd_time == '0));

    p_time_step_r7: assert property (@(posedge clk) disable iff (rst)
        (bwd_busy && bwd_time != TIME_MAX) |=> (bwd_busy && bwd_time == $past(bwd_time) + TIME_W'(1)));

    p_done_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (bwd_busy && bwd_time == TIME_MAX) |=> (bwd_done && !bwd_busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        bwd_done |=> (!bwd_done && !bwd_busy));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (bwd_busy && bwd_time != TIME_MAX) |=> bwd_busy);
endmodule

bind spike_err_encoder spike_err_encoder_chk #(.N_NEUR(N_NEUR)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bwd_spike (bwd_spike),
    .bwd_pol   (bwd_pol),
    .bwd_time  (bwd_time),
    .bwd_busy  (bwd_busy),
    .bwd_done  (bwd_done)
);

// File: tb/spike_err_encoder_tb_top.sv
module spike_err_encoder_tb_top;
    localparam int N  = 10;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N*TW-1:0] act_time = '0, tgt_time = '0;
    logic [N-1:0] act_vld = '0, tgt_vld = '0;
    logic [N-1:0] bwd_spike, bwd_pol;
    logic [TW-1:0] bwd_time;
    logic bwd_busy, bwd_done;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spike_err_encoder #(.N_NEUR(N), .ERR_SHIFT(0)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .act_time(act_time), .act_vld(act_vld),
        .tgt_time(tgt_time), .tgt_vld(tgt_vld),
        .bwd_spike(bwd_spike), .bwd_pol(bwd_pol), .bwd_time(bwd_time),
        .bwd_busy(bwd_busy), .bwd_done(bwd_done)
    );

    int a_t [N], g_t [N];
    bit a_v [N], g_v [N];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply_inputs();
        for (int i = 0; i < N; i++) begin
            act_time[i*TW +: TW] = TW'(a_t[i]);
            tgt_time[i*TW +: TW] = TW'(g_t[i]);
            act_vld[i] = a_v[i];
            tgt_vld[i] = g_v[i];
        end
    endtask

    // one full run; disturb=1 injects a busy-time start and new inputs (R9)
    task automatic run_sample(input string req, input bit disturb);
        int fire_step [N];
        bit fire_pos [N];
        bit fire_any [N];
        for (int i = 0; i < N; i++) begin
            int eff, err;
            eff = a_v[i] ? a_t[i] : 15;             // R4
            err = g_v[i] ? (eff - g_t[i]) : 0;      // R1, R5
            fire_any[i]  = (err != 0);              // R3
            fire_pos[i]  = (err > 0);
            fire_step[i] = 15 - ((err < 0) ? -err : err);  // R2
        end
        apply_inputs();
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 16; t++) begin
            logic [N-1:0] es, ep;
            es = '0; ep = '0;
            for (int i = 0; i < N; i++) begin
                es[i] = fire_any[i] && fire_step[i] == t;
                ep[i] = es[i] && fire_pos[i];
            end
            check({req, " R7 time"}, 64'(bwd_time), 64'(t));
            check({req, " R7 busy"}, 64'(bwd_busy), 64'd1);
            check({req, " R6 spike"}, 64'(bwd_spike), 64'(es));
            check({req, " R1 pol"}, 64'(bwd_pol), 64'(ep));
            if (disturb && t == 5) begin
                for (int i = 0; i < N; i++) begin
                    a_t[i] = (i * 7 + 3) % 16; g_t[i] = (i * 5) % 16;
                    a_v[i] = 1'b1; g_v[i] = 1'b1;
                end
                apply_inputs();
                start = 1'b1;
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0;
        end
        check({req, " R8 done"}, 64'(bwd_done), 64'd1);
        check({req, " R8 busy"}, 64'(bwd_busy), 64'd0);
        check({req, " R8 spike"}, 64'(bwd_spike), 64'd0);
        @(posedge clk); @(negedge clk);
        check({req, " R8 done low"}, 64'(bwd_done), 64'd0);
        check({req, " R8 idle"}, 64'(bwd_busy), 64'd0);
    endtask

    task automatic t_reset();
        check("R10 busy", 64'(bwd_busy), 64'd0);
        check("R10 done", 64'(bwd_done), 64'd0);
        check("R10 spike", 64'(bwd_spike), 64'd0);
        check("R10 pol", 64'(bwd_pol), 64'd0);
        check("R10 time", 64'(bwd_time), 64'd0);
    endtask

    task automatic t_mixed();
        int at [N] = '{15, 0, 7, 3, 9, 12, 1, 8, 14, 5};
        int gt [N] = '{ 0, 15, 4, 10, 9, 2, 1, 0, 13, 11};
        for (int i = 0; i < N; i++) begin
            a_t[i] = at[i]; g_t[i] = gt[i]; a_v[i] = 1'b1; g_v[i] = 1'b1;
        end
        run_sample("R1 R2 mixed", 1'b0);
    endtask

    task automatic t_zero();
        for (int i = 0; i < N; i++) begin
            a_t[i] = i; g_t[i] = i; a_v[i] = 1'b1; g_v[i] = 1'b1;
        end
        run_sample("R3 zero", 1'b0);
    endtask

    task automatic t_silent();
        for (int i = 0; i < N; i++) begin
            a_t[i] = 2; g_t[i] = i + 3; a_v[i] = (i % 2 == 0); g_v[i] = 1'b1;
        end
        run_sample("R4 silent", 1'b0);
    endtask

    task automatic t_no_target();
        for (int i = 0; i < N; i++) begin
            a_t[i] = 15 - i; g_t[i] = 0; a_v[i] = 1'b1; g_v[i] = (i < 3);
        end
        run_sample("R5 no target", 1'b0);
    endtask

    task automatic t_busy_start();
        for (int i = 0; i < N; i++) begin
            a_t[i] = (i * 3) % 16; g_t[i] = 15 - i; a_v[i] = 1'b1; g_v[i] = 1'b1;
        end
        run_sample("R9 busy start", 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_zero();
        t_silent();
        t_no_target();
        t_busy_start();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule